// File: doc/BRIEF.md
# SPI Slave with Select-Gated Transmit Reload

This block is the device side of a four-wire serial link. It takes the clock, data-in and active-low select pins, runs them through synchronizers in its own system clock domain, and finds the clock edges in that domain. Both clock polarities and both phases are supported. A frame is 8 or 16 bits long, and it can be shifted least significant or most significant bit first. Each finished received word goes to the host together with a one-cycle valid strobe.

The block decides what to send in the next frame from how long select stayed high beforehand. If select was high for at least a programmed number of system clocks, the host's transmit word is loaded. If select stayed low, or rose only briefly, the word just received is sent back out. The output-enable is dropped whenever select is high, and this stands for a tristated output.

Top module: `spi_echo_slave`

## Requirements
- R1: `cfg_wide` = 1 makes a frame 16 bits long and `cfg_wide` = 0 makes it 8 bits long. In 8-bit frames `rx_data[15:8]` reads 0.
- R2: `cfg_lsb_first` = 0 moves bit 7 (or 15) first and bit 0 last, in both directions. `cfg_lsb_first` = 1 moves bit 0 first.
- R3: With `cfg_cpha` = 0, the first outgoing bit is on `miso_out` after select falls and before any clock edge. MOSI is sampled on the first edge of each clock cycle, and the output changes on the second edge.
- R4: With `cfg_cpha` = 1, the first edge of each clock cycle presents the outgoing bit (the first edge of a frame presents bit one). MOSI is sampled on the second edge.
- R5: `cfg_cpol` sets the idle level of the clock. With 0, the first edge of a cycle is rising. With 1, it is falling.
- R6: A frame that begins after select has been high for at least `cfg_idle_cnt` system clocks sends `tx_data`. The value used is the one present when the falling select is detected.
- R7: A frame that begins while select has stayed low since the previous frame sends the word received in that previous frame.
- R8: A frame that begins after select was high for fewer than `cfg_idle_cnt` system clocks sends the last received word.
- R9: When the last bit of a frame has been sampled, `rx_valid` is high for exactly one system clock and `rx_data` holds the word at that moment. `rx_data` changes at no other time.
- R10: `miso_oe` is low while select is high and high while select is low, each after the synchronizer delay.
- R11: After reset, `rx_valid` = 0, `rx_data` = 0 and `miso_oe` = 0. The first frame after reset sends `tx_data` even if select was high only briefly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | Clock phase: 0 samples on the first edge, 1 on the second |
| cfg_wide | input | 1 | 1 = 16-bit frames, 0 = 8-bit frames |
| cfg_lsb_first | input | 1 | 1 = least significant bit first |
| cfg_idle_cnt | input | 8 | Minimum select-high time in system clocks |
| tx_data | input | 16 | Host transmit word |
| sck_in | input | 1 | Serial clock pin |
| mosi_in | input | 1 | Serial data in |
| sel_n_in | input | 1 | Active-low select pin |
| miso_out | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for miso_out |
| rx_data | output | 16 | Last received word |
| rx_valid | output | 1 | One-clock strobe for a new received word |

## Verification
Each pin change reaches the logic after two synchronizer stages plus one edge-detect register. An output change is therefore seen about three system clocks after its cause. The bench holds every clock phase for eight system clocks and reads `miso_out` only at the end of a phase. It looks at `rx_data` and the count of `rx_valid` pulses only after the trailing half-period that follows the last sample edge. Select gaps are set to 3 clocks (well below the threshold of 8) or 20 clocks (well above it), so the result of the idle decision is never borderline.

// File: rtl/spi_echo_pkg.sv
`timescale 1ns/1ps
// Shared types for the echo-capable SPI slave.
// Assumes nothing beyond plain SystemVerilog packages.
package spi_echo_pkg;

    // Link configuration bundled for readability at the top level.
    typedef struct packed {
        logic cpol;
        logic cpha;
        logic wide;
        logic lsb_first;
    } spi_mode_t;

    // Frame length in bits for the selected width.
    function automatic int unsigned frame_bits(input logic wide, input int unsigned wide_w,
                                               input int unsigned narrow_w);
        return wide ? wide_w : narrow_w;
    endfunction

endpackage

// File: rtl/spi_echo_sync.sv
`timescale 1ns/1ps
// Multi-bit flip-flop chain synchronizer.
// Each bit is an independent asynchronous level; no bus coherence is assumed.
module spi_echo_sync #(
    parameter int unsigned W          = 3,
    parameter int unsigned STAGES     = 2,
    parameter logic [W-1:0] RST_VAL   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] chain [STAGES];

    // First stage captures the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d_async;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            // Each further stage resamples the one before it.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else        chain[s] <= chain[s-1];
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/spi_echo_edge.sv
`timescale 1ns/1ps
// Serial clock edge classifier.
// Turns the synchronized clock into sample and shift strobes for the mode.
// Assumes the clock is synchronized and slower than clk/4.
module spi_echo_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cpol,
    input  logic cpha,
    input  logic sck_s,
    output logic sample_pulse,
    output logic shift_pulse
);
    logic sck_q;
    logic rise, fall, lead, trail;

    // Delayed copy of the clock, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_s;
    end

    // Classify edges into first and second half of a cycle, then into roles.
    always_comb begin
        rise         = sck_s & ~sck_q;
        fall         = ~sck_s & sck_q;
        lead         = cpol ? fall : rise;
        trail        = cpol ? rise : fall;
        sample_pulse = cpha ? trail : lead;
        shift_pulse  = cpha ? lead  : trail;
    end
endmodule

// File: rtl/spi_echo_idle.sv
`timescale 1ns/1ps
// Select-fall detector and select-high timer.
// idle_ok is true once select has been high for cfg_idle_cnt clocks.
// The timer starts out saturated after reset, so the first frame counts as preceded by idle.
module spi_echo_idle #(
    parameter int unsigned IDLE_CW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_n_s,
    input  logic [IDLE_CW-1:0] cfg_idle_cnt,
    output logic               sel_fall,
    output logic               idle_ok
);
    logic               sel_q;
    logic [IDLE_CW-1:0] high_cnt;

    // Delayed select, used to find the asserting edge.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= 1'b1;
        else        sel_q <= sel_n_s;
    end

    // Saturating count of clocks with select deasserted, cleared while asserted.
    always_ff @(posedge clk) begin
        if (!rst_n)               high_cnt <= '1;
        else if (!sel_n_s)        high_cnt <= '0;
        else if (high_cnt != '1)  high_cnt <= high_cnt + 1'b1;
    end

    // Edge and threshold decode.
    always_comb begin
        sel_fall = sel_q & ~sel_n_s;
        idle_ok  = (high_cnt >= cfg_idle_cnt);
    end
endmodule

// File: rtl/spi_echo_core.sv
`timescale 1ns/1ps
// Shift engine: receive and transmit shift registers, bit counter and reload choice.
// Assumes the strobes come from synchronized inputs, and that mosi_s is aligned with them.
module spi_echo_core #(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned NARROW_W = 8,
    localparam int unsigned CNT_W   = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide,
    input  logic              lsb_first,
    input  logic              sel_active,
    input  logic              sel_fall,
    input  logic              idle_ok,
    input  logic              sample_pulse,
    input  logic              shift_pulse,
    input  logic              mosi_s,
    input  logic [DATA_W-1:0] tx_data,
    output logic              miso_bit,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid
);
    logic [DATA_W-1:0] tx_sh, rx_sh, last_rx, rx_next, mask, tx_shifted;
    logic [CNT_W-1:0]  bit_cnt, frame_len, last_idx;
    logic              frame_done;

    // Width-dependent decode and next-state values for both shifters.
    always_comb begin
        frame_len  = CNT_W'(spi_echo_pkg::frame_bits(wide, DATA_W, NARROW_W));
        last_idx   = frame_len - 1'b1;
        mask       = wide ? {DATA_W{1'b1}}
                          : {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
        if (lsb_first)
            rx_next = ((rx_sh >> 1) | ({{(DATA_W-1){1'b0}}, mosi_s} << last_idx)) & mask;
        else
            rx_next = ((rx_sh << 1) | {{(DATA_W-1){1'b0}}, mosi_s}) & mask;
        tx_shifted = lsb_first ? (tx_sh >> 1) : (tx_sh << 1);
        frame_done = sample_pulse && (bit_cnt == last_idx);
        miso_bit   = lsb_first ? tx_sh[0] : tx_sh[last_idx];
    end

    // Frame sequencing: load on select fall, sample, shift, and complete with reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh    <= '0;
            rx_sh    <= '0;
            last_rx  <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            bit_cnt  <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (!sel_active) begin
                bit_cnt <= '0;
            end else if (sel_fall) begin
                tx_sh   <= (idle_ok ? tx_data : last_rx) & mask;
                rx_sh   <= '0;
                bit_cnt <= '0;
            end else if (frame_done) begin
                rx_data  <= rx_next;
                last_rx  <= rx_next;
                tx_sh    <= rx_next;
                rx_sh    <= '0;
                rx_valid <= 1'b1;
                bit_cnt  <= '0;
            end else if (sample_pulse) begin
                rx_sh   <= rx_next;
                bit_cnt <= bit_cnt + 1'b1;
            end else if (shift_pulse && bit_cnt != '0) begin
                tx_sh   <= tx_shifted;
            end
        end
    end
endmodule

// File: rtl/spi_echo_slave.sv
`timescale 1ns/1ps
// Top of the SPI slave with select-gated transmit reload.
// Pins are synchronized and edges are detected in clk. clk must be at least 4x the serial clock.
// miso_oe stands for the tristate control of the data-out pin.
module spi_echo_slave #(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned NARROW_W    = 8,
    parameter int unsigned IDLE_CW     = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_cpol,
    input  logic               cfg_cpha,
    input  logic               cfg_wide,
    input  logic               cfg_lsb_first,
    input  logic [IDLE_CW-1:0] cfg_idle_cnt,
    input  logic [DATA_W-1:0]  tx_data,
    input  logic               sck_in,
    input  logic               mosi_in,
    input  logic               sel_n_in,
    output logic               miso_out,
    output logic               miso_oe,
    output logic [DATA_W-1:0]  rx_data,
    output logic               rx_valid
);
    import spi_echo_pkg::*;

    spi_mode_t mode;
    logic [2:0] pins_s;
    logic sck_sync, mosi_sync, sel_sync;
    logic sample_pulse, shift_pulse, sel_fall, idle_ok;

    // Gather the mode bits into one bundle.
    always_comb mode = '{cpol: cfg_cpol, cpha: cfg_cpha, wide: cfg_wide, lsb_first: cfg_lsb_first};

    spi_echo_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({sel_n_in, mosi_in, sck_in}),
        .q_sync  (pins_s)
    );

    // Split the synchronized pin vector.
    always_comb {sel_sync, mosi_sync, sck_sync} = pins_s;

    spi_echo_edge u_edge (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpol         (mode.cpol),
        .cpha         (mode.cpha),
        .sck_s        (sck_sync),
        .sample_pulse (sample_pulse),
        .shift_pulse  (shift_pulse)
    );

    spi_echo_idle #(.IDLE_CW(IDLE_CW)) u_idle (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel_n_s      (sel_sync),
        .cfg_idle_cnt (cfg_idle_cnt),
        .sel_fall     (sel_fall),
        .idle_ok      (idle_ok)
    );

    spi_echo_core #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .wide         (mode.wide),
        .lsb_first    (mode.lsb_first),
        .sel_active   (~sel_sync),
        .sel_fall     (sel_fall),
        .idle_ok      (idle_ok),
        .sample_pulse (sample_pulse),
        .shift_pulse  (shift_pulse),
        .mosi_s       (mosi_sync),
        .tx_data      (tx_data),
        .miso_bit     (miso_out),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid)
    );

    // The output is driven only while select is asserted.
    always_comb miso_oe = ~sel_sync;
endmodule

// File: rtl/spi_echo_slave_chk.sv
`timescale 1ns/1ps
// Property checker for spi_echo_slave, attached with bind.
module spi_echo_slave_chk #(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned NARROW_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wide,
    input logic              sel_n_in,
    input logic              sel_sync,
    input logic              miso_oe,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_valid
);
    // R9
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R9
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> rx_data == $past(rx_data));

    // R9
    valid_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !$past(sel_sync));

    // R1
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !cfg_wide) |-> rx_data[DATA_W-1:NARROW_W] == '0);

    // R10
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n_in && $past(sel_n_in) && $past(sel_n_in, 2)) |-> !miso_oe);
endmodule

bind spi_echo_slave spi_echo_slave_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wide (cfg_wide),
    .sel_n_in (sel_n_in),
    .sel_sync (sel_sync),
    .miso_oe  (miso_oe),
    .rx_data  (rx_data),
    .rx_valid (rx_valid)
);

// File: tb/spi_echo_slave_test.sv
`timescale 1ns/1ps
// Sweep over all 16 mode combinations. Each one runs a four-frame sequence:
// tx load, back-to-back echo, echo after a short select pulse, tx load after a long gap.
module spi_echo_slave_test;
    localparam int H = 8;       // system clocks per serial half period
    localparam int LONG_GAP = 20;
    localparam int SHORT_GAP = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_cpol = 0, cfg_cpha = 0, cfg_wide = 0, cfg_lsb_first = 0;
    logic [7:0]  cfg_idle_cnt = 8'd8;
    logic [15:0] tx_data = '0;
    logic sck_in = 0, mosi_in = 0, sel_n_in = 1;
    logic miso_out, miso_oe, rx_valid;
    logic [15:0] rx_data;

    int checks = 0, errors = 0, pulses = 0;
    logic [15:0] cap_data = '0;
    bit done = 0;

    always #2.5 clk = ~clk;

    spi_echo_slave uut (
        .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_wide(cfg_wide), .cfg_lsb_first(cfg_lsb_first), .cfg_idle_cnt(cfg_idle_cnt),
        .tx_data(tx_data), .sck_in(sck_in), .mosi_in(mosi_in), .sel_n_in(sel_n_in),
        .miso_out(miso_out), .miso_oe(miso_oe), .rx_data(rx_data), .rx_valid(rx_valid)
    );

    // Pulse monitor, sampling just after each rising edge.
    always @(posedge clk) begin
        #1;
        if (rx_valid) begin
            pulses++;
            cap_data = rx_data;
        end
    end

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Act as master for one frame; miso_w collects what the slave sent.
    task automatic do_frame(input logic [15:0] mosi_w, output logic [15:0] miso_w);
        int n = cfg_wide ? 16 : 8;
        miso_w = '0;
        if (!cfg_cpha) mosi_in = mosi_w[cfg_lsb_first ? 0 : n-1];
        sel_n_in = 1'b0;
        wait_clk(H);
        check(miso_oe == 1'b1, "R10 oe on", 16'(miso_oe), 16'd1);
        for (int k = 0; k < n; k++) begin
            int p = cfg_lsb_first ? k : n-1-k;
            if (!cfg_cpha) begin
                miso_w[p] = miso_out;
                sck_in = ~cfg_cpol;
                wait_clk(H);
                sck_in = cfg_cpol;
                if (k < n-1) mosi_in = mosi_w[cfg_lsb_first ? k+1 : n-2-k];
                wait_clk(H);
            end else begin
                sck_in = ~cfg_cpol;
                mosi_in = mosi_w[p];
                wait_clk(H);
                miso_w[p] = miso_out;
                sck_in = cfg_cpol;
                wait_clk(H);
            end
        end
    endtask

    // Run one frame and check reception, strobe count and the sent word.
    task automatic frame_check(input logic [15:0] mosi_w, input logic [15:0] exp_miso,
                               input string src_req, output logic [15:0] got_rx);
        logic [15:0] mask = cfg_wide ? 16'hFFFF : 16'h00FF;
        logic [15:0] miso_w;
        int p0 = pulses;
        string mtag = $sformatf("mode cpol=%0d cpha=%0d wide=%0d lsb=%0d %s",
                                cfg_cpol, cfg_cpha, cfg_wide, cfg_lsb_first,
                                cfg_cpha ? "R4" : "R3");
        do_frame(mosi_w, miso_w);
        wait_clk(2);
        check(pulses - p0 == 1, {"R9 one strobe ", mtag}, 16'(pulses - p0), 16'd1);
        check(cap_data == (mosi_w & mask), {"R1 R2 R5 rx word ", mtag}, cap_data, mosi_w & mask);
        check(rx_data == (mosi_w & mask), {"R9 rx hold ", mtag}, rx_data, mosi_w & mask);
        check(miso_w == (exp_miso & mask), {src_req, " tx word ", mtag}, miso_w, exp_miso & mask);
        got_rx = mosi_w & mask;
    endtask

    initial begin
        wait_clk(4);
        check(rx_valid == 1'b0, "R11 valid low", 16'(rx_valid), 16'd0);
        check(rx_data == 16'd0, "R11 data zero", rx_data, 16'd0);
        check(miso_oe == 1'b0, "R11 oe low", 16'(miso_oe), 16'd0);
        rst_n = 1'b1;
        wait_clk(2);
        for (int cfg = 0; cfg < 16; cfg++) begin
            logic [15:0] ta, td, wa, wb, wc, wd, ra, rb, rc, rd;
            {cfg_cpol, cfg_cpha, cfg_wide, cfg_lsb_first} = 4'(cfg);
            sck_in = cfg_cpol;
            wait_clk(cfg == 0 ? 0 : LONG_GAP);
            ta = 16'((cfg * 16'h1357) ^ 16'hA5C3);
            td = 16'((cfg * 16'h0F1D) ^ 16'h3C96);
            wa = 16'((cfg * 16'h2469) + 16'h8E17);
            wb = 16'((cfg * 16'h7B31) ^ 16'h5AF0);
            wc = 16'((cfg * 16'h1C0B) + 16'h6D2A);
            wd = 16'((cfg * 16'h3D85) ^ 16'hC14E);
            tx_data = ta;
            frame_check(wa, ta, cfg == 0 ? "R11 R6" : "R6", ra);
            tx_data = ~ta;
            frame_check(wb, ra, "R7", rb);
            sel_n_in = 1'b1;
            wait_clk(SHORT_GAP);
            frame_check(wc, rb, "R8", rc);
            sel_n_in = 1'b1;
            wait_clk(LONG_GAP);
            tx_data = td;
            frame_check(wd, td, "R6", rd);
            sel_n_in = 1'b1;
            wait_clk(LONG_GAP);
            check(miso_oe == 1'b0, "R10 oe off", 16'(miso_oe), 16'd0);
            check(rx_data == rd, "R9 rx kept after frame", rx_data, rd);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule